// File: doc/BRIEF.md
# Indexed Block Register Slave on a Two-Wire Serial Bus

This block is a serial-bus slave in front of the control register file of a clock generator. It listens on the SCL and SDA lines and pulls SDA low through an open-drain drive signal. It accepts two fixed address bytes. D2h opens a write. D3h opens a read. Each access starts at a register index that the master sends. The rest of the chip reads every control byte in parallel from a flat output vector.

A write gives an index, then a byte count N, then N data bytes. These land on consecutive registers. A read gives the index in a write phase, then a repeated START and the read address. The slave then returns a stored count byte, followed by register data from the index upward. The master can stop a read after any byte. Some bytes are read-only identification codes. One status byte holds three strap pins captured during reset. Reserved bits keep their reset value whatever is written to them.

Top module: `smb_regfile_slave`

## Requirements
- R1: SCL and SDA pass through synchronisers into the system clock. A START is an SDA fall while SCL is high. A STOP is an SDA rise while SCL is high. SDA changes while SCL is low are data bits. A START at any point restarts address decoding.
- R2: After START, address byte D2h is acknowledged, and so are the index byte and a non-zero count N. Each of the next N data bytes is acknowledged and written to index, index+1, and so on.
- R3: A count byte of 00h is not acknowledged, no register changes, and later bytes are ignored until the next START.
- R4: A data byte that arrives after N bytes have been written is not acknowledged and writes nothing.
- R5: After the index byte, a repeated START with address D3h is acknowledged. The slave sends the count register (index 8, reset value 08h) first. It then sends register data from the index upward, one register per byte the master acknowledges.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and ignores SCL pulses until the next START or STOP. A single-byte read ends this way after the first data byte.
- R7: Any address byte other than D2h and D3h is not acknowledged, and the bus is ignored until the next START.
- R8: A write changes only the writable bits. Read-only and reserved bits are kept: index 0 bits 7:5, index 6 bits 2:0, index 9 bits 7 and 3, index 12 bit 3, index 13 bit 7, and all of index 7 (05h), index 14 (20h) and index 15 (15h).
- R9: Index 6 bits 2:0 hold the strap pins as sampled during reset. Strap changes after reset have no effect.
- R10: After reset the registers hold these values: index 0 = 1Fh, 1 = FFh, 2 = FFh, 3 = 00h, 4 = 0Fh, 5 = 00h, 6 = 58h OR strap, 7 = 05h, 8 = 08h, 9 = 11h, 10 = 96h, 11 = 96h, 12 = 27h, 13 = 00h, 14 = 20h, 15 = 15h.
- R11: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| scl_in | input | 1 | Serial clock line as seen on the bus |
| sda_in | input | 1 | Serial data line as seen on the bus (wired-AND of all drivers) |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| strap_in | input | 3 | Frequency-select strap pins |
| cfg_bytes | output | NUM_REGS*8 | All register bytes; index i occupies bits 8i+7:8i |

## Verification
Single-byte writes, each followed by a readback, are driven from a table of indices. The table covers fully writable, partly reserved, strap-holding and read-only registers, so each mask shows up as a different readback value. Multi-byte writes and reads check that the index increments and that the count byte comes first.

Several abnormal sequences are tried:
- a zero count
- an extra data byte after N bytes
- an unknown address
- a master NACK partway through a read

Each of these separates "ignored until START" from "still responding". A change to the count register confirms that a read returns the stored count and not a constant.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

    localparam logic [7:0] WR_ADDR   = 8'hD2;
    localparam logic [7:0] RD_ADDR   = 8'hD3;
    localparam int         COUNT_IDX = 8;
    localparam int         STRAP_IDX = 6;
    localparam int         STRAP_W   = 3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_OFFS, ST_COUNT, ST_WDATA,
        ST_ACK, ST_TX, ST_MACK, ST_IGNORE
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } wr_req_t;

    function automatic logic [7:0] init_val(int idx);
        case (idx)
            0:  return 8'h1F;
            1:  return 8'hFF;
            2:  return 8'hFF;
            4:  return 8'h0F;
            6:  return 8'h58;
            7:  return 8'h05;
            8:  return 8'h08;
            9:  return 8'h11;
            10: return 8'h96;
            11: return 8'h96;
            12: return 8'h27;
            14: return 8'h20;
            15: return 8'h15;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] wmask(int idx);
        case (idx)
            0:  return 8'h1F;
            6:  return 8'hF8;
            7:  return 8'h00;
            9:  return 8'h77;
            12: return 8'hF7;
            13: return 8'h7F;
            14: return 8'h00;
            15: return 8'h00;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smbreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int MSB = SYNC_STAGES - 1;

    logic [MSB:0] scl_pipe, sda_pipe;
    logic         scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[MSB-1:0], scl_in};
            sda_pipe <= {sda_pipe[MSB-1:0], sda_in};
            scl_q    <= scl_pipe[MSB];
            sda_q    <= sda_pipe[MSB];
        end
    end

    always_comb begin
        ev.scl      = scl_pipe[MSB];
        ev.sda      = sda_pipe[MSB];
        ev.scl_rise = scl_pipe[MSB] & ~scl_q;
        ev.scl_fall = ~scl_pipe[MSB] & scl_q;
        ev.start    = scl_pipe[MSB] & scl_q & sda_q & ~sda_pipe[MSB];
        ev.stop     = scl_pipe[MSB] & scl_q & ~sda_q & sda_pipe[MSB];
    end

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smbreg_pkg::*;
#(
    parameter int NUM_REGS = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [STRAP_W-1:0]    strap,
    input  wr_req_t               wr,
    input  logic [7:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] cfg_flat
);
    localparam int         IDX_W = $clog2(NUM_REGS);
    localparam logic [8:0] NUM9  = 9'(NUM_REGS);

    logic [7:0]       regs [NUM_REGS];
    logic [IDX_W-1:0] widx;
    logic             wr_hit;

    always_comb begin
        widx   = wr.addr[IDX_W-1:0];
        wr_hit = wr.en && ({1'b0, wr.addr} < NUM9);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= init_val(i);
            regs[STRAP_IDX][STRAP_W-1:0] <= strap;
        end else if (wr_hit) begin
            regs[widx] <= (regs[widx] & ~wmask(int'(widx)))
                        | (wr.data & wmask(int'(widx)));
        end
    end

    always_comb begin
        if ({1'b0, rd_addr} < NUM9) rd_data = regs[rd_addr[IDX_W-1:0]];
        else                        rd_data = 8'h00;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
        assign cfg_flat[g*8 +: 8] = regs[g];
    end

    // R8: protected bits survive a write
    assert_ro_bits_kept_R8: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (((regs[$past(widx)] ^ $past(regs[widx]))
                     & ~wmask(int'($past(widx)))) == 8'h00));

    // R9: strap copy holds after reset
    assert_strap_hold_R9: assert property (@(posedge clk) disable iff (rst)
        $stable(regs[STRAP_IDX][STRAP_W-1:0]));

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
    import smbreg_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_addr,
    output wr_req_t wr,
    output logic    sda_drive
);
    phase_e     phase, after_ack;
    logic [7:0] shreg, ptr, remain, txreg;
    logic [3:0] bcnt;
    logic [2:0] tcnt;
    logic       send_count, mnack;

    always_comb rd_addr = send_count ? 8'(COUNT_IDX) : ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= ST_IDLE;
            after_ack  <= ST_IDLE;
            shreg      <= '0;
            ptr        <= '0;
            remain     <= '0;
            txreg      <= '0;
            bcnt       <= '0;
            tcnt       <= '0;
            send_count <= 1'b0;
            mnack      <= 1'b0;
            sda_drive  <= 1'b0;
            wr         <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.stop) begin
                phase     <= ST_IDLE;
                sda_drive <= 1'b0;
            end else if (ev.start) begin
                phase      <= ST_ADDR;
                bcnt       <= '0;
                send_count <= 1'b0;
                sda_drive  <= 1'b0;
            end else begin
                case (phase)
                    ST_ADDR, ST_OFFS, ST_COUNT, ST_WDATA: begin
                        if (ev.scl_rise) begin
                            shreg <= {shreg[6:0], ev.sda};
                            bcnt  <= bcnt + 4'd1;
                        end else if (ev.scl_fall && bcnt == 4'd8) begin
                            bcnt <= '0;
                            case (phase)
                                ST_ADDR: begin
                                    if (shreg == WR_ADDR) begin
                                        sda_drive <= 1'b1;
                                        after_ack <= ST_OFFS;
                                        phase     <= ST_ACK;
                                    end else if (shreg == RD_ADDR) begin
                                        sda_drive  <= 1'b1;
                                        send_count <= 1'b1;
                                        after_ack  <= ST_TX;
                                        phase      <= ST_ACK;
                                    end else begin
                                        phase <= ST_IGNORE;
                                    end
                                end
                                ST_OFFS: begin
                                    ptr       <= shreg;
                                    sda_drive <= 1'b1;
                                    after_ack <= ST_COUNT;
                                    phase     <= ST_ACK;
                                end
                                ST_COUNT: begin
                                    if (shreg == 8'h00) begin
                                        phase <= ST_IGNORE;
                                    end else begin
                                        remain    <= shreg;
                                        sda_drive <= 1'b1;
                                        after_ack <= ST_WDATA;
                                        phase     <= ST_ACK;
                                    end
                                end
                                default: begin
                                    if (remain != 8'h00) begin
                                        wr.en     <= 1'b1;
                                        wr.addr   <= ptr;
                                        wr.data   <= shreg;
                                        ptr       <= ptr + 8'd1;
                                        remain    <= remain - 8'd1;
                                        sda_drive <= 1'b1;
                                        after_ack <= ST_WDATA;
                                        phase     <= ST_ACK;
                                    end else begin
                                        phase <= ST_IGNORE;
                                    end
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (ev.scl_fall) begin
                            phase <= after_ack;
                            if (after_ack == ST_TX) begin
                                txreg     <= rd_data;
                                tcnt      <= '0;
                                sda_drive <= ~rd_data[7];
                                if (send_count) send_count <= 1'b0;
                                else            ptr <= ptr + 8'd1;
                            end else begin
                                sda_drive <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (tcnt == 3'd7) begin
                                sda_drive <= 1'b0;
                                phase     <= ST_MACK;
                            end else begin
                                txreg     <= {txreg[6:0], 1'b0};
                                sda_drive <= ~txreg[6];
                                tcnt      <= tcnt + 3'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            mnack <= ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mnack) begin
                                phase <= ST_IGNORE;
                            end else begin
                                txreg     <= rd_data;
                                tcnt      <= '0;
                                sda_drive <= ~rd_data[7];
                                ptr       <= ptr + 8'd1;
                                phase     <= ST_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a START always restarts address decoding
    assert_start_to_addr_R1: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !ev.stop) |=> (phase == ST_ADDR));

    // R6: STOP leaves SDA released
    assert_stop_release_R6: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_drive);

    // R7: nothing is driven while the bus is ignored
    assert_ignore_silent_R7: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IGNORE) |-> !sda_drive);

    // R11: drive is steady through an SCL high phase
    assert_drive_steady_R11: assert property (@(posedge clk) disable iff (rst)
        (ev.scl && !ev.scl_rise && !$past(ev.start) && !$past(ev.stop))
            |-> $stable(sda_drive));

endmodule

// File: rtl/smb_regfile_slave.sv
module smb_regfile_slave
    import smbreg_pkg::*;
#(
    parameter int NUM_REGS    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_drive_low,
    input  logic [STRAP_W-1:0]    strap_in,
    output logic [NUM_REGS*8-1:0] cfg_bytes
);
    bus_ev_t    ev;
    wr_req_t    wr;
    logic [7:0] rd_addr, rd_data;

    smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in), .ev(ev)
    );

    smb_proto_fsm u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .rd_data(rd_data),
        .rd_addr(rd_addr), .wr(wr), .sda_drive(sda_drive_low)
    );

    smb_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk(clk), .rst(rst), .strap(strap_in), .wr(wr),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_flat(cfg_bytes)
    );

endmodule

// File: tb/test_smb_regfile_slave.sv
module test_smb_regfile_slave;
    localparam int NR = 16;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic [2:0]      strap = 3'b101;
    logic            drv;
    logic [NR*8-1:0] cfg;
    wire             sda_line = sda_m & ~drv;

    int total = 0;
    int fails = 0;
    int viol  = 0;
    int cyc   = 0;
    logic scl_prev = 1'b1, drv_prev = 1'b0;

    logic [7:0] rbuf [4];
    logic [7:0] rcount;
    logic       ack_all;

    always #10 clk = ~clk;

    smb_regfile_slave #(.NUM_REGS(NR)) i_smb_regfile_slave (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
        .sda_drive_low(drv), .strap_in(strap), .cfg_bytes(cfg)
    );

    // R11 monitor: drive change with SCL high on both samples
    always @(posedge clk) begin
        if (!rst && scl_m && scl_prev && (drv != drv_prev)) viol++;
        scl_prev <= scl_m;
        drv_prev <= drv;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    function automatic logic [7:0] reg_at(int i);
        return cfg[i*8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wclk(6); scl_m = 1'b1; wclk(10); scl_m = 1'b0; wclk(6);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(6); scl_m = 1'b1; wclk(6); sda_m = 1'b0; wclk(6);
        scl_m = 1'b0; wclk(6);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(6); scl_m = 1'b1; wclk(6); sda_m = 1'b1; wclk(6);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wclk(6); scl_m = 1'b1; wclk(5);
        ack = ~sda_line; wclk(5); scl_m = 1'b0; wclk(6);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic m_ack);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            sda_m = 1'b1; wclk(6); scl_m = 1'b1; wclk(5);
            b = {b[6:0], sda_line}; wclk(5); scl_m = 1'b0; wclk(6);
        end
        send_bit(~m_ack);
    endtask

    task automatic wr_one(input logic [7:0] off, input logic [7:0] d);
        logic a;
        ack_all = 1'b1;
        bus_start();
        send_byte(8'hD2, a); ack_all &= a;
        send_byte(off, a);   ack_all &= a;
        send_byte(8'h01, a); ack_all &= a;
        send_byte(d, a);     ack_all &= a;
        bus_stop();
    endtask

    task automatic rd_seq(input logic [7:0] off, input int n);
        logic a;
        ack_all = 1'b1;
        bus_start();
        send_byte(8'hD2, a); ack_all &= a;
        send_byte(off, a);   ack_all &= a;
        bus_start();
        send_byte(8'hD3, a); ack_all &= a;
        recv_byte(rcount, 1'b1);
        for (int i = 0; i < n; i++) recv_byte(rbuf[i], i < n - 1);
        bus_stop();
    endtask

    typedef struct packed {
        logic [7:0] off;
        logic [7:0] data;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{8'd0,  8'hFF, 8'h1F},
        '{8'd3,  8'hA5, 8'hA5},
        '{8'd6,  8'h07, 8'h05},
        '{8'd7,  8'hFF, 8'h05},
        '{8'd9,  8'hFF, 8'h77},
        '{8'd12, 8'hFF, 8'hF7},
        '{8'd13, 8'hFF, 8'h7F},
        '{8'd14, 8'h00, 8'h20},
        '{8'd15, 8'h00, 8'h15}
    };

    initial begin
        logic a;
        logic [7:0] b;
        wclk(5);
        rst = 1'b0;
        wclk(5);

        // R10 reset values, R9 strap capture
        chk("R10 idx0", reg_at(0), 8'h1F);
        chk("R10 idx1", reg_at(1), 8'hFF);
        chk("R10 idx8", reg_at(8), 8'h08);
        chk("R10 idx10", reg_at(10), 8'h96);
        chk("R10 idx14", reg_at(14), 8'h20);
        chk("R9 strap at reset", reg_at(6), 8'h5D);
        strap = 3'b010;
        wclk(10);
        chk("R9 strap change ignored", reg_at(6), 8'h5D);

        // R8 / R2 / R1 table walk
        for (int i = 0; i < 9; i++) begin
            wr_one(VECS[i].off, VECS[i].data);
            chk("R1 R2 write acked", {7'd0, ack_all}, 8'h01);
            chk("R8 port value", reg_at(int'(VECS[i].off)), VECS[i].exp);
            rd_seq(VECS[i].off, 1);
            chk("R8 readback", rbuf[0], VECS[i].exp);
        end

        // R2 multi-byte write
        ack_all = 1'b1;
        bus_start();
        send_byte(8'hD2, a); ack_all &= a;
        send_byte(8'h03, a); ack_all &= a;
        send_byte(8'h03, a); ack_all &= a;
        send_byte(8'h11, a); ack_all &= a;
        send_byte(8'h22, a); ack_all &= a;
        send_byte(8'h33, a); ack_all &= a;
        bus_stop();
        chk("R2 block acks", {7'd0, ack_all}, 8'h01);
        chk("R2 idx3", reg_at(3), 8'h11);
        chk("R2 idx4", reg_at(4), 8'h22);
        chk("R2 idx5", reg_at(5), 8'h33);

        // R5 multi-byte read with count first
        rd_seq(8'h03, 3);
        chk("R5 read acks", {7'd0, ack_all}, 8'h01);
        chk("R5 count byte", rcount, 8'h08);
        chk("R5 data0", rbuf[0], 8'h11);
        chk("R5 data1", rbuf[1], 8'h22);
        chk("R5 data2", rbuf[2], 8'h33);
        rd_seq(8'h0E, 2);
        chk("R5 id14", rbuf[0], 8'h20);
        chk("R5 id15", rbuf[1], 8'h15);

        // R6 master NACK ends read
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h04, a);
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(b, 1'b1);
        recv_byte(b, 1'b0);
        chk("R6 first data", b, 8'h22);
        wclk(8);
        chk("R6 sda released", {7'd0, drv}, 8'h00);
        recv_byte(b, 1'b1);
        chk("R6 later pulses ignored", b, 8'hFF);
        bus_stop();
        rd_seq(8'h03, 1);
        chk("R6 next read works", rbuf[0], 8'h11);

        // R3 zero count
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h01, a);
        send_byte(8'h00, a);
        chk("R3 zero count nack", {7'd0, a}, 8'h00);
        send_byte(8'h5A, a);
        chk("R3 data ignored", {7'd0, a}, 8'h00);
        bus_stop();
        chk("R3 idx1 unchanged", reg_at(1), 8'hFF);

        // R4 data past count
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h05, a);
        send_byte(8'h01, a);
        send_byte(8'h44, a);
        chk("R4 in-count ack", {7'd0, a}, 8'h01);
        send_byte(8'h55, a);
        chk("R4 extra nack", {7'd0, a}, 8'h00);
        bus_stop();
        chk("R4 idx5 written", reg_at(5), 8'h44);
        chk("R4 idx6 untouched", reg_at(6), 8'h05);

        // R7 unknown address
        bus_start();
        send_byte(8'hA0, a);
        chk("R7 bad addr nack", {7'd0, a}, 8'h00);
        send_byte(8'hD2, a);
        chk("R7 ignored until START", {7'd0, a}, 8'h00);
        bus_stop();
        rd_seq(8'h00, 1);
        chk("R7 recovers", rbuf[0], 8'h1F);

        // R5 count register is stored, not fixed
        wr_one(8'h08, 8'h02);
        rd_seq(8'h03, 2);
        chk("R5 updated count", rcount, 8'h02);
        chk("R5 data after count", rbuf[1], 8'h22);

        chk("R11 drive change while SCL high", 8'(viol), 8'h00);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule